// File: doc/BRIEF.md
# Addressable Bit Latch with Decoder Mode

This block holds eight single-bit storage locations that are filled one bit at a time. A three-bit select picks the location, a serial data input supplies the value, and two active-low controls (a load enable and a clear) choose one of four behaviours: write the selected bit, hold everything, decode the select into a one-hot output gated by the data bit, or force everything low. It serves as a serial-to-parallel collector for scattered control bits and doubles as a one-of-eight decoder when the clear is held.

Storage is a clocked register updated on the rising edge of `clk`. The outputs are combinational from the stored bits and the live inputs, so in load and decode modes the selected output follows the data input within the same cycle. A write takes effect in storage at the clock edge, so the value retained when the load enable is released is the last data bit sampled while it was low.

Top module: `addr_bit_latch`

## Requirements
- R1: While `rst_n` is low the storage is cleared asynchronously. After reset, in hold mode (`clear_n`=1, `load_n`=1), `bits_o` is 8'h00.
- R2: In load mode (`clear_n`=1, `load_n`=0), output bit `sel` equals `din` in the same cycle, and every other output bit equals its stored value.
- R3: In load mode, at each rising clock edge the stored bit chosen by `sel` takes the value of `din`; the other stored bits are unchanged, so on leaving load mode the retained value is the `din` sampled at the last edge in load mode.
- R4: In hold mode (`clear_n`=1, `load_n`=1), `bits_o` equals the stored bits regardless of `din` and `sel`, and storage does not change at the clock edge.
- R5: In decode mode (`clear_n`=0, `load_n`=0), output bit `sel` equals `din` and all other seven output bits are 0.
- R6: In clear mode (`clear_n`=0, `load_n`=1), `bits_o` is 8'h00 regardless of `sel` and `din`.
- R7: In both decode mode and clear mode all stored bits become 0 at the clock edge, so a following hold cycle shows 8'h00.
- R8: Select value n (0..7, `sel[0]` least significant) addresses output bit `bits_o[n]` and stored bit n in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the storage register |
| rst_n | input | 1 | Asynchronous active-low reset of the storage |
| din | input | 1 | Serial data bit |
| sel | input | 3 | Bit select, value n addresses bit n |
| load_n | input | 1 | Active-low load enable |
| clear_n | input | 1 | Active-low common clear |
| bits_o | output | 8 | Parallel outputs |

## Verification
The bench sweeps every select value in decode mode with the data bit at both levels; a decoder with swapped select bits or a lost data gate would light the wrong output or light one when the data is low. It loads a pattern one bit at a time and then toggles data and select in hold mode, where a design that kept writing or that bypassed the stored value would show a changed pattern. It passes through decode and clear modes before returning to hold, where a design that only masked the outputs without clearing storage would bring back the old pattern. A long random run of mode, select and data values is compared every cycle against a behavioural model, catching a same-cycle follow path that was registered by mistake.

// File: rtl/abl_pkg.sv
package abl_pkg;

  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,  // clear_n=0, load_n=0
    MODE_CLEAR  = 2'b01,  // clear_n=0, load_n=1
    MODE_LOAD   = 2'b10,  // clear_n=1, load_n=0
    MODE_HOLD   = 2'b11   // clear_n=1, load_n=1
  } abl_mode_e;

endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
  import abl_pkg::*;
(
  input  logic      clear_n,
  input  logic      load_n,
  output abl_mode_e mode
);

  always_comb begin
    unique case ({clear_n, load_n})
      2'b00:   mode = MODE_DECODE;
      2'b01:   mode = MODE_CLEAR;
      2'b10:   mode = MODE_LOAD;
      default: mode = MODE_HOLD;
    endcase
  end

endmodule

// File: rtl/abl_store.sv
module abl_store
  import abl_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  abl_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic [NBITS-1:0] store_q
);

  logic [NBITS-1:0] store_nxt;
  logic             store_en;

  // clock enable: everything except hold mode may change storage
  assign store_en = (mode != MODE_HOLD);

  always_comb begin
    store_nxt = store_q;
    unique case (mode)
      MODE_LOAD:              store_nxt[sel] = din;
      MODE_DECODE, MODE_CLEAR: store_nxt = '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (store_en) begin
      store_q <= store_nxt;
    end
  end

  assert_load_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> (store_q[$past(sel)] == $past(din)));

  assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(store_q));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DECODE || mode == MODE_CLEAR) |=> (store_q == '0));

endmodule

// File: rtl/abl_out_mux.sv
module abl_out_mux
  import abl_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  abl_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  input  logic [NBITS-1:0] store_q,
  output logic [NBITS-1:0] bits_o
);

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    logic hit;
    assign hit = (sel == SEL_W'(g));
    always_comb begin
      unique case (mode)
        MODE_LOAD:   bits_o[g] = hit ? din : store_q[g];
        MODE_HOLD:   bits_o[g] = store_q[g];
        MODE_DECODE: bits_o[g] = hit & din;
        default:     bits_o[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import abl_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             load_n,
  input  logic             clear_n,
  output logic [NBITS-1:0] bits_o
);

  abl_mode_e        mode;
  logic [NBITS-1:0] store_q;

  abl_mode_dec u_dec (
    .clear_n (clear_n),
    .load_n  (load_n),
    .mode    (mode)
  );

  abl_store #(.SEL_W(SEL_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .sel     (sel),
    .din     (din),
    .store_q (store_q)
  );

  abl_out_mux #(.SEL_W(SEL_W)) u_mux (
    .mode    (mode),
    .sel     (sel),
    .din     (din),
    .store_q (store_q),
    .bits_o  (bits_o)
  );

  assert_clear_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && load_n) |-> (bits_o == '0));

  assert_decode_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && !load_n) |-> ($onehot0(bits_o) && ((bits_o != '0) == din)));

  assert_load_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |-> (bits_o[sel] == din));

  assert_hold_shows_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n) |-> (bits_o == store_q));

endmodule

// File: tb/test_addr_bit_latch.sv
module test_addr_bit_latch;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       din;
  logic [2:0] sel;
  logic       load_n;
  logic       clear_n;
  logic [7:0] bits_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model;   // behavioural copy of stored bits

  always #4 clk = ~clk;  // 125 MHz

  addr_bit_latch i_addr_bit_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .sel     (sel),
    .load_n  (load_n),
    .clear_n (clear_n),
    .bits_o  (bits_o)
  );

  function automatic logic [7:0] expect_out(logic c, logic l, logic d, int s, logic [7:0] m);
    logic [7:0] r;
    r = m;
    if (c && !l) r[s] = d;          // load: selected follows data
    else if (c && l) r = m;         // hold
    else if (!c && !l) begin        // decode
      r = 8'h00;
      r[s] = d;
    end else r = 8'h00;             // clear
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // drive at negedge, compare mid-low phase, then update model at posedge
  task automatic step(logic c, logic l, logic d, int s, string tag);
    @(negedge clk);
    clear_n = c; load_n = l; din = d; sel = 3'(s);
    #2;
    check(tag, bits_o, expect_out(c, l, d, s, model));
    @(posedge clk);
    if (c && !l) model[s] = d;
    else if (!c) model = 8'h00;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = 1'b1; sel = 3'd5; load_n = 1'b1; clear_n = 1'b1;
    model = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 1, 1, 5, "R1 reset state");

    // decode sweep every select, both data values
    for (int s = 0; s < 8; s++) begin
      step(0, 0, 1, s, "R5 R8 decode data high");
      step(0, 0, 0, s, "R5 decode data low");
    end

    // load pattern A5 one bit at a time
    for (int s = 0; s < 8; s++) step(1, 0, (8'hA5 >> s) & 1, s, "R2 R8 load follow");
    step(1, 1, 0, 0, "R3 pattern retained");
    check("R3 pattern value", bits_o, 8'hA5);
    // hold ignores din and sel
    for (int s = 0; s < 8; s++) step(1, 1, ~((8'hA5 >> s) & 1), s, "R4 hold ignores inputs");
    check("R4 storage unchanged", bits_o, 8'hA5);

    // last sample before leaving load mode wins
    step(1, 0, 1, 1, "R2 load high");
    step(1, 0, 0, 1, "R2 load low");
    step(1, 1, 1, 1, "R3 last sample retained");
    check("R3 bit1 cleared", bits_o, 8'hA5);

    // clear mode then hold shows zeros
    step(0, 1, 1, 3, "R6 clear mode low");
    step(1, 1, 1, 3, "R7 after clear");
    check("R7 zero after clear", bits_o, 8'h00);

    // decode mode also empties storage
    for (int s = 0; s < 8; s++) step(1, 0, 1, s, "R2 fill ones");
    step(0, 0, 1, 6, "R5 decode over full store");
    step(1, 1, 0, 6, "R7 after decode");
    check("R7 zero after decode", bits_o, 8'h00);

    // random mode sequences
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 3));
      step(r[1], r[0], 1'($urandom), int'($urandom_range(0, 7)), "R2/R4/R5/R6 random");
    end

    // reset while storage is non-zero
    for (int s = 0; s < 8; s++) step(1, 0, 1, s, "R2 refill");
    @(negedge clk);
    rst_n = 1'b0; clear_n = 1'b1; load_n = 1'b1;
    #2;
    check("R1 async reset clears", bits_o, 8'h00);
    model = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 1, 1, 2, "R1 after second reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule